// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects single-cycle event pulses from the surrounding decoder logic and turns them into two kinds of host-visible state. The first is a set of sticky status bits that the host polls. The second is an active-low interrupt pin. Each event has its own status bit and its own mask bit. The status bit is captured whether or not the event is masked. An unmasked event also sets a hidden per-register pin latch. The interrupt pin is asserted while any of those latches is set.

The host reaches the block through a plain synchronous register bus. Reading a status register returns its bits and clears them. That read does not release the pin. The pin stays asserted until the host writes a release command to the control register. This lets the host read every status register before acknowledging the interrupt, so an event that arrives during that scan cannot be lost.

Top module: `irqs_top`

## Requirements
- R1: A one-cycle event pulse on `evt_pulse[n]` sets status bit n at the next clock edge. The bit stays set until a read of its register clears it.
- R2: Status bit n is found at address n/8, bit position n%8, over addresses 0 to 4. In register 4 only bits 0 and 1 are implemented, and bits 2 to 7 always read 0.
- R3: A read (`bus_rd`=1) returns the addressed register on `bus_rdata` one cycle later. If the read targets a status register, the bits read are cleared at the same edge.
- R4: If an event pulse arrives in the same cycle as a read of its status register, the read returns the old value and the bit is 1 afterwards.
- R5: The mask registers sit at addresses 8 to 12 and use the same bit layout as the status registers. They are readable and writable. A mask bit of 1 keeps its event away from the pin but still lets the status bit set. Unimplemented mask bits read 0.
- R6: An unmasked event drives `irq_n` low at the clock edge that samples it.
- R7: Reading the status registers does not release `irq_n`.
- R8: Writing a 1 to bit 0 of address 6 releases `irq_n` at that edge. Writing 0 to that bit has no effect. Address 6 always reads 0.
- R9: If an unmasked event arrives in the same cycle as a release write, `irq_n` stays low.
- R10: Reset clears all status bits and pin latches, drives `irq_n` high, and sets every implemented mask bit to 1.
- R11: Writes to the status registers and to unused addresses have no effect. Reads of unused addresses (5, 7, 13 to 15) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 34 | One-cycle event pulses, one per status bit |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read also clears that status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid one cycle after `bus_rd` |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
A status bit that is lost or stuck becomes visible on the next read of its register, one cycle after the read strobe. A second read then shows whether the clear took effect. A corrupted pin latch shows on `irq_n` at the first edge after the event, the read or the release write, because the pin is checked every cycle against a model. A wrong mask bit shows either directly on mask readback or as a pin that asserts, or fails to assert, one cycle after its event. The collision cases are placed cycle-exact, because losing either the set or the clear leaves a wrong value that persists until the next read.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  // Number of implemented bits in group g of a bank holding n bits in groups of w.
  function automatic int grp_bits(int n, int w, int g);
    int left;
    left = n - g * w;
    if (left >= w) return w;
    if (left <= 0) return 0;
    return left;
  endfunction

endpackage

// File: rtl/irqs_group.sv
module irqs_group #(
  parameter int W      = 8,
  parameter int VALID_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         rd_clr,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  input  logic         pin_clr,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         latch_q,
  output logic         latch_nx
);

  localparam logic [W-1:0] VMASK = {W{1'b1}} >> (W - VALID_W);

  logic [W-1:0] evt_v;
  logic         hit;

  assign evt_v    = evt & VMASK;
  assign hit      = |(evt_v & ~mask);
  assign latch_nx = (latch_q & ~pin_clr) | hit;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (rd_clr ? '0 : status) | evt_v;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask <= VMASK;
    else if (mask_we) mask <= wdata & VMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= latch_nx;
  end

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((status & $past(status)) == $past(status)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_v) |=> ((status & $past(evt_v)) == $past(evt_v)));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(|evt_v)) |=> (status == '0));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !pin_clr) |=> latch_q);

endmodule

// File: rtl/irqs_readmux.sv
module irqs_readmux #(
  parameter int ADDR_W    = 4,
  parameter int REG_W     = 8,
  parameter int NUM_REGS  = 5,
  parameter int MASK_BASE = 8
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_REGS*REG_W-1:0] stat_all,
  input  logic [NUM_REGS*REG_W-1:0] mask_all,
  output logic [REG_W-1:0]          data
);

  always_comb begin
    data = '0;
    for (int g = 0; g < NUM_REGS; g++) begin
      if (addr == ADDR_W'(g))             data = stat_all[g*REG_W +: REG_W];
      if (addr == ADDR_W'(MASK_BASE + g)) data = mask_all[g*REG_W +: REG_W];
    end
  end

endmodule

// File: rtl/irqs_top.sv
module irqs_top #(
  parameter int NUM_EVENTS = 34,
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 4,
  parameter int MASK_BASE  = 8,
  parameter int CTRL_ADDR  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] evt_pulse,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  output logic                  irq_n
);

  import irqs_pkg::*;

  localparam int NUM_REGS = (NUM_EVENTS + REG_W - 1) / REG_W;
  localparam int PAD_W    = NUM_REGS * REG_W;

  logic [PAD_W-1:0]    evt_pad;
  logic [PAD_W-1:0]    stat_all;
  logic [PAD_W-1:0]    mask_all;
  logic [NUM_REGS-1:0] lat_q;
  logic [NUM_REGS-1:0] lat_nx;
  logic [REG_W-1:0]    rd_mux;
  logic                pin_clr;
  logic                unmasked_any;

  assign evt_pad      = PAD_W'(evt_pulse);
  assign pin_clr      = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR)) && bus_wdata[0];
  assign unmasked_any = |(evt_pad & ~mask_all);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_grp
    localparam int VW = grp_bits(NUM_EVENTS, REG_W, g);
    irqs_group #(.W(REG_W), .VALID_W(VW)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_pad[g*REG_W +: REG_W]),
      .rd_clr  (bus_rd && (bus_addr == ADDR_W'(g))),
      .mask_we (bus_wr && (bus_addr == ADDR_W'(MASK_BASE + g))),
      .wdata   (bus_wdata),
      .pin_clr (pin_clr),
      .status  (stat_all[g*REG_W +: REG_W]),
      .mask    (mask_all[g*REG_W +: REG_W]),
      .latch_q (lat_q[g]),
      .latch_nx(lat_nx[g])
    );
  end

  irqs_readmux #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .MASK_BASE(MASK_BASE)
  ) u_mux (
    .addr    (bus_addr),
    .stat_all(stat_all),
    .mask_all(mask_all),
    .data    (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(|lat_nx);
  end

  // R6
  irq_pin_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|lat_q));

  // R8
  pin_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_clr && !unmasked_any) |=> irq_n);

  // R9
  clear_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_clr && unmasked_any) |=> !irq_n);

endmodule

// File: tb/irqs_top_test.sv
module irqs_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [33:0] evt_pulse = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_n;

  always #10 clk = ~clk;

  irqs_top uut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  typedef struct {
    bit         is_rd;
    logic [7:0] rd;
    bit         irqn;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  logic [39:0] m_stat = '0;
  logic [39:0] m_mask = {6'h00, 34'h3_FFFF_FFFF};
  logic [4:0]  m_lat  = '0;

  function automatic logic [7:0] grp(logic [39:0] v, int g);
    return v[g*8 +: 8];
  endfunction

  task automatic cyc(input logic [33:0] ev, input bit wr, input bit rd,
                     input int addr, input logic [7:0] wd, input string tag);
    item_t it;
    logic [39:0] ev40;
    bit clr;
    @(negedge clk);
    evt_pulse = ev; bus_wr = wr; bus_rd = rd; bus_addr = 4'(addr); bus_wdata = wd;
    ev40 = {6'h00, ev};
    it.is_rd = rd;
    it.rd = 8'h00;
    it.tag = tag;
    if (rd) begin
      if (addr >= 0 && addr <= 4)  it.rd = grp(m_stat, addr);
      if (addr >= 8 && addr <= 12) it.rd = grp(m_mask, addr - 8);
    end
    clr = wr && addr == 6 && wd[0];
    for (int g = 0; g < 5; g++)
      m_lat[g] = (clr ? 1'b0 : m_lat[g]) | (|(grp(ev40, g) & ~grp(m_mask, g)));
    if (rd && addr >= 0 && addr <= 4) m_stat[addr*8 +: 8] = 8'h00;
    if (wr && addr >= 8 && addr <= 12)
      m_mask[(addr-8)*8 +: 8] = wd & ((addr == 12) ? 8'h03 : 8'hFF);
    m_stat = m_stat | ev40;
    it.irqn = ~(|m_lat);
    q.push_back(it);
  endtask

  task automatic rd(input int a, input string tag);  cyc('0, 0, 1, a, 8'h00, tag); endtask
  task automatic wr(input int a, input logic [7:0] d, input string tag); cyc('0, 1, 0, a, d, tag); endtask
  task automatic ev(input logic [33:0] e, input string tag); cyc(e, 0, 0, 0, 8'h00, tag); endtask
  task automatic idle(input string tag); cyc('0, 0, 0, 0, 8'h00, tag); endtask

  // monitor: checks each queued item a quarter period after the edge that produced it
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (irq_n !== it.irqn) begin
        fails++;
        $display("FAIL %s irq_n: actual %b expected %b", it.tag, irq_n, it.irqn);
      end
      if (it.is_rd) begin
        total++;
        if (bus_rdata !== it.rd) begin
          fails++;
          $display("FAIL %s rdata: actual %h expected %h", it.tag, bus_rdata, it.rd);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    total++;
    if (irq_n !== 1'b1) begin
      fails++;
      $display("FAIL R10 irq_n after reset: actual %b expected 1", irq_n);
    end
    // R10 reset state of status and masks
    for (int a = 0; a <= 4; a++) rd(a, "R10");
    for (int a = 8; a <= 12; a++) rd(a, "R10_R5");
    rd(6, "R8");
    rd(5, "R11"); rd(7, "R11"); rd(14, "R11");
    // R5 masked event sets status but not pin
    ev(34'd1 << 3, "R5");
    idle("R5");
    rd(0, "R1");
    rd(0, "R3");
    // unmask everything
    for (int a = 8; a <= 12; a++) wr(a, 8'h00, "R5");
    rd(12, "R5");
    // R6 unmasked event on top bit
    ev(34'd1 << 33, "R6");
    idle("R1");
    rd(4, "R2");
    idle("R7");
    rd(4, "R3");
    wr(6, 8'h00, "R8");
    wr(6, 8'h01, "R8");
    rd(6, "R8");
    // R4 collision of event with read-clear
    cyc(34'd1 << 10, 0, 1, 1, 8'h00, "R4");
    rd(1, "R4");
    wr(6, 8'h01, "R8");
    // R9 collision of event with pin release
    cyc(34'd1 << 5, 1, 0, 6, 8'h01, "R9");
    idle("R9");
    rd(0, "R9");
    wr(6, 8'h01, "R8");
    // R11 writes to status and unused addresses ignored
    ev(34'd1 << 17, "R11");
    wr(2, 8'hFF, "R11");
    wr(0, 8'hFF, "R11");
    wr(13, 8'hFF, "R11");
    rd(0, "R11");
    rd(2, "R11");
    rd(13, "R11");
    wr(6, 8'h01, "R8");
    // R5 partial mask in register 1
    wr(9, 8'h01, "R5");
    rd(9, "R5");
    ev(34'd1 << 8, "R5");
    idle("R5");
    ev(34'd1 << 9, "R6");
    rd(1, "R1");
    wr(6, 8'h01, "R8");
    // R2 all events at once
    ev('1, "R2");
    for (int a = 0; a <= 4; a++) rd(a, "R2");
    wr(12, 8'hFF, "R5");
    rd(12, "R5");
    wr(6, 8'h01, "R8");
    ev(34'd1 << 32, "R5");
    rd(4, "R5");
    idle("R7");
    idle("R7");
    repeat (3) @(posedge clk);
    #6;
    finish_run();
  end

endmodule